// File: doc/BRIEF.md
# Peripheral Access Protection Gate

This block sits between a single APB-style requester and a bank of downstream peripheral ports. External address decode picks one port per transfer with a one-hot select vector. For each transfer the gate compares the transfer's protection attributes with two configuration bits for the selected port: whether it may be reached by non-secure transfers, and whether it may be reached by unprivileged transfers.

A permitted transfer passes straight through to the selected port, and that port's response comes back unchanged. A refused transfer never reaches the peripheral. The gate answers it itself, either with a transfer error or with a quiet completion: reads return zero and writes are dropped. A refusal can also set a sticky interrupt flag.

There is no register interface. All configuration comes in on input wires. An elaboration-time mask can exempt chosen ports from the security comparison.

Top module: `ppg_gate`

## Requirements
- R1: When a transfer is permitted, `ds_psel` equals `up_psel` and `ds_penable` follows `up_penable`. Address, write data, direction and protection are forwarded unchanged. `up_prdata`, `up_pready` and `up_pslverr` are taken from the selected port's response.
- R2: A transfer with `up_pprot[1]`=1 (non-secure) to an unexempt port whose `cfg_nonsec_ok` bit is 0 is refused.
- R3: A transfer with `up_pprot[1]`=0 (secure) to an unexempt port whose `cfg_nonsec_ok` bit is 1 is refused.
- R4: A transfer with `up_pprot[0]`=0 (unprivileged) to a port whose `cfg_unpriv_ok` bit is 0 is refused, whatever its security state.
- R5: For ports whose bit is set in the parameter `SEC_EXEMPT`, the security comparison is skipped in both directions. The privilege rule of R4 still applies to them.
- R6: A refused transfer drives `ds_psel` all zero and `ds_penable` low.
- R7: While a refused transfer is selected, the gate answers it in the same cycle: `up_pready`=1 and `up_prdata`=0. `up_pslverr` equals `cfg_err_resp` (1 means error, 0 means quiet completion).
- R8: A refused transfer in its access phase (`up_penable`=1) sets `irq` from the next cycle, but only if `irq_en`=1. With `irq_en`=0, `irq` is not set.
- R9: Once set, `irq` stays high until a cycle with `irq_clr`=1, and is low in the cycle after it. If a clear and a new refusal arrive in the same cycle, the clear wins.
- R10: While `rst` is high, `irq` is cleared. It reads 0 in the first cycle after reset.
- R11: With `up_psel` all zero there is no downstream select or enable, `up_pready`, `up_pslverr` and `up_prdata` are 0, and `irq` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_psel | input | NUM_PORTS | One-hot port select from decode |
| up_penable | input | 1 | Access phase marker |
| up_pwrite | input | 1 | Write when 1 |
| up_pprot | input | 3 | Protection; bit0 privileged, bit1 non-secure |
| up_paddr | input | ADDR_W | Transfer address |
| up_pwdata | input | DATA_W | Write data |
| up_prdata | output | DATA_W | Read data to requester |
| up_pready | output | 1 | Transfer complete |
| up_pslverr | output | 1 | Transfer error |
| ds_psel | output | NUM_PORTS | Gated per-port selects |
| ds_penable | output | 1 | Gated access phase marker |
| ds_pwrite | output | 1 | Forwarded direction |
| ds_pprot | output | 3 | Forwarded protection |
| ds_paddr | output | ADDR_W | Forwarded address |
| ds_pwdata | output | DATA_W | Forwarded write data |
| ds_prdata | input | NUM_PORTS*DATA_W | Per-port read data, port i at bits i*DATA_W upward |
| ds_pready | input | NUM_PORTS | Per-port ready |
| ds_pslverr | input | NUM_PORTS | Per-port error |
| cfg_nonsec_ok | input | NUM_PORTS | Port reachable by non-secure transfers |
| cfg_unpriv_ok | input | NUM_PORTS | Port reachable by unprivileged transfers |
| cfg_err_resp | input | 1 | Refusal answered with error (1) or quietly (0) |
| irq_en | input | 1 | Allow refusals to set the interrupt |
| irq_clr | input | 1 | Clear the interrupt |
| irq | output | 1 | Sticky refusal interrupt |

## Verification
The verdict path is purely combinational. A wrong permission decision therefore shows up in the same cycle, either as a stray or missing `ds_psel` bit or as a locally generated response where the peripheral's response belonged. The only stored state is the interrupt flag. A fault there shows up one cycle after the triggering access or clear, or as a flag that drops or rises with no cause. The checks compare every cycle against a bench model, so such a fault is reported within one clock.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    // Decoded protection attributes of one transfer
    typedef struct packed {
        logic nonsec;
        logic priv;
    } acc_attr_t;

    typedef enum logic [1:0] {
        VERDICT_IDLE  = 2'd0,
        VERDICT_PASS  = 2'd1,
        VERDICT_BLOCK = 2'd2
    } verdict_e;

    // Field positions inside the 3-bit protection vector
    localparam int PROT_PRIV_BIT   = 0;
    localparam int PROT_NONSEC_BIT = 1;

    function automatic acc_attr_t decode_prot(input logic [2:0] prot);
        acc_attr_t a;
        a.priv   = prot[PROT_PRIV_BIT];
        a.nonsec = prot[PROT_NONSEC_BIT];
        return a;
    endfunction

    // One port's permission decision
    function automatic logic port_permits(input acc_attr_t a,
                                          input logic      ns_ok,
                                          input logic      up_ok,
                                          input logic      exempt);
        logic sec_ok;
        logic prv_ok;
        sec_ok = exempt | (a.nonsec == ns_ok);
        prv_ok = a.priv | up_ok;
        return sec_ok & prv_ok;
    endfunction

endpackage

// File: rtl/ppg_port_check.sv
module ppg_port_check
    import ppg_pkg::*;
#(
    parameter int                   NUM_PORTS  = 16,
    parameter logic [NUM_PORTS-1:0] SEC_EXEMPT = '0
) (
    input  acc_attr_t              attr,
    input  logic [NUM_PORTS-1:0]   cfg_nonsec_ok,
    input  logic [NUM_PORTS-1:0]   cfg_unpriv_ok,
    output logic [NUM_PORTS-1:0]   allow
);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        if (SEC_EXEMPT[i]) begin : g_exempt
            assign allow[i] = port_permits(attr, 1'b0, cfg_unpriv_ok[i], 1'b1);
        end else begin : g_checked
            assign allow[i] = port_permits(attr, cfg_nonsec_ok[i], cfg_unpriv_ok[i], 1'b0);
        end
    end

endmodule

// File: rtl/ppg_resp_mux.sv
module ppg_resp_mux #(
    parameter int NUM_PORTS = 16,
    parameter int DATA_W    = 32
) (
    input  logic [NUM_PORTS-1:0]        sel,
    input  logic [NUM_PORTS*DATA_W-1:0] rdata_in,
    input  logic [NUM_PORTS-1:0]        ready_in,
    input  logic [NUM_PORTS-1:0]        err_in,
    output logic [DATA_W-1:0]           rdata,
    output logic                        ready,
    output logic                        err
);

    logic [DATA_W-1:0] masked [NUM_PORTS];

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_mask
        assign masked[i] = rdata_in[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}};
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            rdata = rdata | masked[i];
        end
        ready = |(ready_in & sel);
        err   = |(err_in & sel);
    end

endmodule

// File: rtl/ppg_irq.sv
module ppg_irq (
    input  logic clk,
    input  logic rst,
    input  logic reject_pulse,
    input  logic irq_en,
    input  logic irq_clr,
    output logic irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end else if (reject_pulse && irq_en) begin
            irq_q <= 1'b1;
        end
    end

    assign irq = irq_q;

    AST_IRQ_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> !irq); // R9
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R9
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        (reject_pulse && irq_en && !irq_clr) |=> irq); // R8
    AST_IRQ_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!irq && !(reject_pulse && irq_en)) |=> !irq); // R8

endmodule

// File: rtl/ppg_gate.sv
module ppg_gate
    import ppg_pkg::*;
#(
    parameter int                   NUM_PORTS  = 16,
    parameter int                   ADDR_W     = 12,
    parameter int                   DATA_W     = 32,
    parameter logic [NUM_PORTS-1:0] SEC_EXEMPT = '0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        up_psel,
    input  logic                        up_penable,
    input  logic                        up_pwrite,
    input  logic [2:0]                  up_pprot,
    input  logic [ADDR_W-1:0]           up_paddr,
    input  logic [DATA_W-1:0]           up_pwdata,
    output logic [DATA_W-1:0]           up_prdata,
    output logic                        up_pready,
    output logic                        up_pslverr,
    output logic [NUM_PORTS-1:0]        ds_psel,
    output logic                        ds_penable,
    output logic                        ds_pwrite,
    output logic [2:0]                  ds_pprot,
    output logic [ADDR_W-1:0]           ds_paddr,
    output logic [DATA_W-1:0]           ds_pwdata,
    input  logic [NUM_PORTS*DATA_W-1:0] ds_prdata,
    input  logic [NUM_PORTS-1:0]        ds_pready,
    input  logic [NUM_PORTS-1:0]        ds_pslverr,
    input  logic [NUM_PORTS-1:0]        cfg_nonsec_ok,
    input  logic [NUM_PORTS-1:0]        cfg_unpriv_ok,
    input  logic                        cfg_err_resp,
    input  logic                        irq_en,
    input  logic                        irq_clr,
    output logic                        irq
);

    acc_attr_t              attr;
    logic [NUM_PORTS-1:0]   allow;
    verdict_e               verdict;
    logic [DATA_W-1:0]      mux_rdata;
    logic                   mux_ready;
    logic                   mux_err;
    logic                   reject_pulse;

    assign attr = decode_prot(up_pprot);

    ppg_port_check #(
        .NUM_PORTS  (NUM_PORTS),
        .SEC_EXEMPT (SEC_EXEMPT)
    ) u_check (
        .attr          (attr),
        .cfg_nonsec_ok (cfg_nonsec_ok),
        .cfg_unpriv_ok (cfg_unpriv_ok),
        .allow         (allow)
    );

    always_comb begin
        if (up_psel == '0) begin
            verdict = VERDICT_IDLE;
        end else if ((up_psel & allow) != '0) begin
            verdict = VERDICT_PASS;
        end else begin
            verdict = VERDICT_BLOCK;
        end
    end

    ppg_resp_mux #(
        .NUM_PORTS (NUM_PORTS),
        .DATA_W    (DATA_W)
    ) u_mux (
        .sel      (up_psel),
        .rdata_in (ds_prdata),
        .ready_in (ds_pready),
        .err_in   (ds_pslverr),
        .rdata    (mux_rdata),
        .ready    (mux_ready),
        .err      (mux_err)
    );

    // Request side: only the select and enable are gated
    assign ds_psel    = (verdict == VERDICT_PASS) ? up_psel : '0;
    assign ds_penable = (verdict == VERDICT_PASS) && up_penable;
    assign ds_pwrite  = up_pwrite;
    assign ds_pprot   = up_pprot;
    assign ds_paddr   = up_paddr;
    assign ds_pwdata  = up_pwdata;

    // Response side
    always_comb begin
        unique case (verdict)
            VERDICT_PASS: begin
                up_prdata  = mux_rdata;
                up_pready  = mux_ready;
                up_pslverr = mux_err;
            end
            VERDICT_BLOCK: begin
                up_prdata  = '0;
                up_pready  = 1'b1;
                up_pslverr = cfg_err_resp;
            end
            default: begin
                up_prdata  = '0;
                up_pready  = 1'b0;
                up_pslverr = 1'b0;
            end
        endcase
    end

    assign reject_pulse = (verdict == VERDICT_BLOCK) && up_penable;

    ppg_irq u_irq (
        .clk          (clk),
        .rst          (rst),
        .reject_pulse (reject_pulse),
        .irq_en       (irq_en),
        .irq_clr      (irq_clr),
        .irq          (irq)
    );

    AST_DS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ds_psel)); // R1
    AST_DS_MATCHES_UP: assert property (@(posedge clk) disable iff (rst)
        (ds_psel != '0) |-> (ds_psel == up_psel)); // R1
    AST_UNPRIV_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!up_pprot[0] && ((up_psel & ~cfg_unpriv_ok) != '0)) |-> (ds_psel == '0 && !ds_penable)); // R4
    AST_REFUSED_ANSWER: assert property (@(posedge clk) disable iff (rst)
        (up_psel != '0 && ds_psel == '0) |-> (up_pready && up_prdata == '0 && up_pslverr == cfg_err_resp)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (up_psel == '0) |-> (!ds_penable && !up_pready && !up_pslverr)); // R11

endmodule

// File: tb/tb_ppg_gate.sv
`timescale 1ns/1ps
module tb_ppg_gate;

    localparam int NP = 16;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam logic [NP-1:0] EXEMPT = 16'h8001;

    logic              clk = 1'b0;
    logic              rst;
    logic [NP-1:0]     up_psel;
    logic              up_penable, up_pwrite;
    logic [2:0]        up_pprot;
    logic [AW-1:0]     up_paddr;
    logic [DW-1:0]     up_pwdata;
    logic [DW-1:0]     up_prdata;
    logic              up_pready, up_pslverr;
    logic [NP-1:0]     ds_psel;
    logic              ds_penable, ds_pwrite;
    logic [2:0]        ds_pprot;
    logic [AW-1:0]     ds_paddr;
    logic [DW-1:0]     ds_pwdata;
    logic [NP*DW-1:0]  ds_prdata;
    logic [NP-1:0]     ds_pready, ds_pslverr;
    logic [NP-1:0]     cfg_nonsec_ok, cfg_unpriv_ok;
    logic              cfg_err_resp, irq_en, irq_clr, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_irq;

    always #2.5 clk = ~clk;

    ppg_gate #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .SEC_EXEMPT(EXEMPT)) dut (
        .clk(clk), .rst(rst),
        .up_psel(up_psel), .up_penable(up_penable), .up_pwrite(up_pwrite),
        .up_pprot(up_pprot), .up_paddr(up_paddr), .up_pwdata(up_pwdata),
        .up_prdata(up_prdata), .up_pready(up_pready), .up_pslverr(up_pslverr),
        .ds_psel(ds_psel), .ds_penable(ds_penable), .ds_pwrite(ds_pwrite),
        .ds_pprot(ds_pprot), .ds_paddr(ds_paddr), .ds_pwdata(ds_pwdata),
        .ds_prdata(ds_prdata), .ds_pready(ds_pready), .ds_pslverr(ds_pslverr),
        .cfg_nonsec_ok(cfg_nonsec_ok), .cfg_unpriv_ok(cfg_unpriv_ok),
        .cfg_err_resp(cfg_err_resp), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sel_index(input logic [NP-1:0] s);
        for (int i = 0; i < NP; i++) if (s[i]) return i;
        return -1;
    endfunction

    // Expected permission, from the requirements
    function automatic bit exp_allow(input int p, input logic [2:0] prot);
        bit sec_ok, prv_ok;
        sec_ok = EXEMPT[p] || (prot[1] == cfg_nonsec_ok[p]);   // R2 R3 R5
        prv_ok = prot[0] || cfg_unpriv_ok[p];                  // R4
        return sec_ok && prv_ok;
    endfunction

    // Compare all outputs against the model, then advance the irq model
    task automatic check_cycle();
        int p;
        bit ok_acc;
        string tag;
        #1;
        p = sel_index(up_psel);
        chk(irq === exp_irq, "R8/R9 irq", irq, exp_irq);
        chk(ds_paddr === up_paddr && ds_pwdata === up_pwdata && ds_pwrite === up_pwrite
            && ds_pprot === up_pprot, "R1 forward", ds_paddr, up_paddr);
        if (p < 0) begin
            chk(ds_psel === '0 && !ds_penable && !up_pready && !up_pslverr && up_prdata === '0,
                "R11 idle", {ds_psel, up_pready}, 0);
            ok_acc = 1'b0;
        end else begin
            ok_acc = exp_allow(p, up_pprot);
            if (ok_acc) begin
                chk(ds_psel === up_psel && ds_penable === up_penable, "R1 select",
                    {ds_psel, ds_penable}, {up_psel, up_penable});
                chk(up_prdata === ds_prdata[p*DW +: DW] && up_pready === ds_pready[p]
                    && up_pslverr === ds_pslverr[p], "R1 response",
                    up_prdata, ds_prdata[p*DW +: DW]);
            end else begin
                tag = !up_pprot[0] && !cfg_unpriv_ok[p] ? "R4" :
                      EXEMPT[p] ? "R5" : up_pprot[1] ? "R2" : "R3";
                chk(ds_psel === '0 && !ds_penable, {"R6 blocked ", tag},
                    {ds_psel, ds_penable}, 0);
                chk(up_pready === 1'b1 && up_prdata === '0 && up_pslverr === cfg_err_resp,
                    "R7 answer", {up_pready, up_pslverr, up_prdata}, {1'b1, cfg_err_resp, 32'h0});
            end
        end
        if (irq_clr) exp_irq = 1'b0;
        else if (p >= 0 && !ok_acc && up_penable && irq_en) exp_irq = 1'b1;
        @(posedge clk);
    endtask

    task automatic rand_inputs();
        int r;
        r = $urandom_range(0, 7);
        up_psel       = (r == 0) ? '0 : (NP'(1) << $urandom_range(0, NP-1));
        up_penable    = 1'($urandom);
        up_pwrite     = 1'($urandom);
        up_pprot      = 3'($urandom);
        up_paddr      = AW'($urandom);
        up_pwdata     = $urandom;
        for (int i = 0; i < NP; i++) ds_prdata[i*DW +: DW] = $urandom;
        ds_pready     = NP'($urandom);
        ds_pslverr    = NP'($urandom);
        cfg_nonsec_ok = NP'($urandom);
        cfg_unpriv_ok = NP'($urandom);
        cfg_err_resp  = 1'($urandom);
        irq_en        = 1'($urandom);
        irq_clr       = ($urandom_range(0, 9) == 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rand_inputs();
        irq_clr = 1'b0;
        rst = 1'b1;
        exp_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(irq === 1'b0, "R10 reset irq", irq, 0);
        @(posedge clk);

        // Directed: refused secure access to non-secure-only port 3, irq disabled (R3, R8)
        @(negedge clk);
        up_psel = 16'h0008; up_penable = 1; up_pprot = 3'b001;
        cfg_nonsec_ok = 16'h0008; cfg_unpriv_ok = '1; cfg_err_resp = 1; irq_en = 0; irq_clr = 0;
        check_cycle();
        @(negedge clk); up_psel = '0; check_cycle();
        // Same refusal with irq enabled, then hold (R8 R9)
        @(negedge clk); up_psel = 16'h0008; irq_en = 1; cfg_err_resp = 0; check_cycle();
        @(negedge clk); up_psel = '0; check_cycle();
        @(negedge clk); check_cycle();
        // Clear together with a new refusal: clear wins (R9)
        @(negedge clk); up_psel = 16'h0008; irq_clr = 1; check_cycle();
        @(negedge clk); up_psel = '0; irq_clr = 0; check_cycle();
        // Exempt port 15, non-secure, privileged, config says secure-only: passes (R5)
        @(negedge clk); up_psel = 16'h8000; up_pprot = 3'b011; cfg_nonsec_ok = '0; check_cycle();
        // Exempt port 0, unprivileged with no unprivileged access: refused (R5 R4)
        @(negedge clk); up_psel = 16'h0001; up_pprot = 3'b010; cfg_unpriv_ok = '0; check_cycle();
        // No select with irq enabled (R11)
        @(negedge clk); up_psel = '0; irq_clr = 1; check_cycle();
        @(negedge clk); irq_clr = 0; check_cycle();
        @(negedge clk); check_cycle();

        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            rand_inputs();
            check_cycle();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule